// File: doc/BRIEF.md
# Probe Trace Capture Unit

The unit samples a bundle of probe signals into an internal buffer on every clock cycle and later streams the stored samples out, oldest first. It serves as an on-chip logic analyzer: software or a debug agent arms it, chooses a capture mode, waits for the done flag and then drains the buffer. While the buffer drains, the logic being observed keeps running at full clock rate.

There are two capture modes, chosen when the unit is armed. In start-on-trigger mode nothing is stored until the trigger input fires. From that cycle on, one sample per cycle is written until the buffer is full. In stop-on-trigger mode the unit writes continuously into a circular buffer and overwrites its oldest entries. A trigger freezes the buffer, so it keeps the history that led up to the event. The readout stream starts with a header beat that carries the number of valid samples. The samples follow under a valid/ready handshake, and the order is corrected after a wrap so that the oldest sample leaves first.

Top module: `trace_capture`

## Requirements
- R1: After reset, `armed`, `triggered`, `wrapped`, `done` and `rdValid` are all low.
- R2: An `armReq` pulse clears the sample count, both buffer pointers and all flags. In the following cycle `armed` is high, and the mode in effect is the value of `modeStop` sampled with that pulse (1 = stop-on-trigger, 0 = start-on-trigger). An arm request takes priority over a trigger in the same cycle.
- R3: A trigger is ignored whenever the unit is not armed. `triggered` and `done` keep their values, and no readout starts.
- R4: In start-on-trigger mode, no sample taken before the trigger is stored. The probe value present in the trigger cycle is the first stored sample.
- R5: In start-on-trigger mode, capture stops by itself after exactly DEPTH samples. `done` then rises, `wrapped` stays low and the header reports DEPTH.
- R6: In stop-on-trigger mode, one sample is stored on every armed cycle. The probe value in the trigger cycle is the last stored sample. No write follows it, and `done` rises.
- R7: In stop-on-trigger mode, `wrapped` rises once the write position rolls over from the last buffer address to address 0. It stays high until the next arm. The header then reports DEPTH, and the samples read out are the last DEPTH values stored.
- R8: After `done` rises, the first readout beat has `rdHeader` = 1 and carries the count of valid samples, zero-extended, on `rdData`.
- R9: The beats after the header have `rdHeader` = 0 and deliver the stored samples oldest first, one per accepted beat. After the last one is accepted, `rdValid` goes low and stays low until the next capture completes.
- R10: While `rdValid` is high and `rdReady` is low, `rdData` and `rdHeader` hold their values. A beat is consumed only in a cycle where both are high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| armReq | input | 1 | One-cycle pulse that clears state and arms the unit |
| modeStop | input | 1 | Mode sampled with armReq: 1 = stop-on-trigger, 0 = start-on-trigger |
| trigIn | input | 1 | Trigger event |
| probeIn | input | PROBE_W | Signals that are sampled |
| armed | output | 1 | Unit is waiting for a trigger or capturing |
| triggered | output | 1 | A trigger was accepted since the last arm |
| wrapped | output | 1 | Circular buffer rolled over since the last arm |
| done | output | 1 | Capture finished, readout available |
| rdValid | output | 1 | Readout beat valid |
| rdReady | input | 1 | Consumer accepts the current beat |
| rdHeader | output | 1 | Current beat is the sample-count header |
| rdData | output | max(PROBE_W, clog2(DEPTH+1)) | Header count or sample value |

## Verification
The hardest situation to reach is a stop-on-trigger capture that has wrapped. In that case the read pointer must start at the current write position, and an off-by-one at the rollover boundary shows up only for one particular trigger distance. The bench sweeps the trigger distance from one cycle up to past twice the buffer depth. It feeds an arithmetic probe pattern, so the expected oldest-first sequence and count follow directly from the distance. It also drains with a stalling ready pattern to exercise the hold rule, and re-arms in the middle of a capture and after a wrap to show that all state is cleared.

// File: rtl/trace_pkg.sv
package trace_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_CAP,
    ST_HDR,
    ST_DATA,
    ST_END
  } capState_t;

  typedef struct packed {
    logic clrAll;
    logic wrEn;
    logic allowWrap;
    logic rdLoad;
    logic rdAdv;
  } dpCtl_t;

endpackage

// File: rtl/trace_ctrl.sv
module trace_ctrl
  import trace_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          armReq,
  input  logic          modeStop,
  input  logic          trigIn,
  input  logic          rdReady,
  output dpCtl_t        ctl,
  output logic          armedFlag,
  output logic          trigSeen,
  output logic          doneFlag,
  output logic          hdrPhase,
  output logic          rdValid,
  output logic [CW-1:0] sampleCount
);

  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [CW-1:0] LAST_CNT = CW'(DEPTH - 1);

  capState_t state, nextState;
  logic          stopMode;
  logic [CW-1:0] remaining;
  logic          capActive;

  assign capActive = (state == ST_WAIT) || (state == ST_CAP);
  assign armedFlag = capActive;
  assign hdrPhase  = (state == ST_HDR);
  assign rdValid   = (state == ST_HDR) || (state == ST_DATA);

  always_comb begin
    ctl           = '0;
    ctl.allowWrap = stopMode;
    if (armReq) begin
      ctl.clrAll = 1'b1;
    end else begin
      unique case (state)
        ST_WAIT: ctl.wrEn   = trigIn;
        ST_CAP:  ctl.wrEn   = 1'b1;
        ST_HDR:  ctl.rdLoad = rdReady;
        ST_DATA: ctl.rdAdv  = rdReady;
        default: ;
      endcase
    end
  end

  always_comb begin
    nextState = state;
    if (armReq) begin
      nextState = modeStop ? ST_CAP : ST_WAIT;
    end else begin
      unique case (state)
        ST_WAIT: if (trigIn) nextState = (DEPTH == 1) ? ST_HDR : ST_CAP;
        ST_CAP: begin
          if (stopMode) begin
            if (trigIn) nextState = ST_HDR;
          end else if (sampleCount == LAST_CNT) begin
            nextState = ST_HDR;
          end
        end
        ST_HDR:  if (rdReady) nextState = ST_DATA;
        ST_DATA: if (rdReady && remaining == CW'(1)) nextState = ST_END;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state       <= ST_IDLE;
      stopMode    <= 1'b0;
      sampleCount <= '0;
      remaining   <= '0;
      trigSeen    <= 1'b0;
      doneFlag    <= 1'b0;
    end else begin
      state <= nextState;
      if (armReq) begin
        stopMode    <= modeStop;
        sampleCount <= '0;
        remaining   <= '0;
        trigSeen    <= 1'b0;
        doneFlag    <= 1'b0;
      end else begin
        if (ctl.wrEn && sampleCount != FULL_CNT) sampleCount <= sampleCount + CW'(1);
        if (capActive && trigIn) trigSeen <= 1'b1;
        if (capActive && nextState == ST_HDR) doneFlag <= 1'b1;
        if (ctl.rdLoad) remaining <= sampleCount;
        else if (ctl.rdAdv) remaining <= remaining - CW'(1);
      end
    end
  end

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    sampleCount <= FULL_CNT); // R5
  AST_ARM_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    armReq |=> (sampleCount == '0) && !doneFlag && !trigSeen && armedFlag); // R2
  AST_DONE_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    doneFlag && !armReq |=> $stable(sampleCount)); // R6
  AST_WAIT_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WAIT) |-> (sampleCount == '0)); // R4
  AST_IDLE_IGNORE: assert property (@(posedge clk) disable iff (!rstN)
    !capActive && !armReq |=> $stable(trigSeen) && $stable(doneFlag)); // R3

endmodule

// File: rtl/trace_datapath.sv
module trace_datapath
  import trace_pkg::*;
#(
  parameter int PROBE_W = 16,
  parameter int DEPTH   = 64,
  parameter int AW      = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               rstN,
  input  dpCtl_t             ctl,
  input  logic [PROBE_W-1:0] probeIn,
  output logic               wrappedFlag,
  output logic [PROBE_W-1:0] rdWord
);

  localparam logic [AW-1:0] LAST_ADDR = AW'(DEPTH - 1);

  logic [PROBE_W-1:0] store [DEPTH];
  logic [AW-1:0]      wrPtr;
  logic [AW-1:0]      rdPtr;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == LAST_ADDR) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (ctl.wrEn) store[wrPtr] <= probeIn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr       <= '0;
      rdPtr       <= '0;
      wrappedFlag <= 1'b0;
    end else if (ctl.clrAll) begin
      wrPtr       <= '0;
      rdPtr       <= '0;
      wrappedFlag <= 1'b0;
    end else begin
      if (ctl.wrEn) begin
        wrPtr <= bump(wrPtr);
        if (wrPtr == LAST_ADDR && ctl.allowWrap) wrappedFlag <= 1'b1;
      end
      if (ctl.rdLoad) rdPtr <= wrappedFlag ? wrPtr : '0;
      else if (ctl.rdAdv) rdPtr <= bump(rdPtr);
    end
  end

  assign rdWord = store[rdPtr];

  AST_WRAP_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    wrappedFlag && !ctl.clrAll |=> wrappedFlag); // R7
  AST_NO_WRITE_IN_READ: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.rdLoad || ctl.rdAdv) |-> !ctl.wrEn); // R6

endmodule

// File: rtl/trace_capture.sv
module trace_capture
  import trace_pkg::*;
#(
  parameter int PROBE_W = 16,
  parameter int DEPTH   = 64,
  localparam int AW     = $clog2(DEPTH),
  localparam int CW     = $clog2(DEPTH + 1),
  localparam int DW     = (PROBE_W > CW) ? PROBE_W : CW
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               armReq,
  input  logic               modeStop,
  input  logic               trigIn,
  input  logic [PROBE_W-1:0] probeIn,
  output logic               armed,
  output logic               triggered,
  output logic               wrapped,
  output logic               done,
  output logic               rdValid,
  input  logic               rdReady,
  output logic               rdHeader,
  output logic [DW-1:0]      rdData
);

  dpCtl_t             ctl;
  logic [CW-1:0]      sampleCount;
  logic [PROBE_W-1:0] rdWord;

  trace_ctrl #(.DEPTH(DEPTH), .CW(CW)) u_ctrl (
    .clk(clk), .rstN(rstN), .armReq(armReq), .modeStop(modeStop),
    .trigIn(trigIn), .rdReady(rdReady), .ctl(ctl), .armedFlag(armed),
    .trigSeen(triggered), .doneFlag(done), .hdrPhase(rdHeader),
    .rdValid(rdValid), .sampleCount(sampleCount)
  );

  trace_datapath #(.PROBE_W(PROBE_W), .DEPTH(DEPTH), .AW(AW)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .probeIn(probeIn),
    .wrappedFlag(wrapped), .rdWord(rdWord)
  );

  assign rdData = rdHeader ? DW'(sampleCount) : DW'(rdWord);

  AST_HOLD_BEAT: assert property (@(posedge clk) disable iff (!rstN)
    rdValid && !rdReady && !armReq |=> rdValid && $stable(rdData) && $stable(rdHeader)); // R10
  AST_START_NO_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    done && !ctl.allowWrap |-> !wrapped); // R5

endmodule

// File: tb/trace_capture_test.sv
module trace_capture_test;

  localparam int PW = 8;
  localparam int DP = 8;
  localparam int DW = 8;

  logic clk = 0;
  logic rstN = 0;
  logic armReq = 0, modeStop = 0, trigIn = 0, rdReady = 0;
  logic [PW-1:0] probeIn = '0;
  logic armed, triggered, wrapped, done, rdValid, rdHeader;
  logic [DW-1:0] rdData;

  int total = 0;
  int bad = 0;
  int expv [0:63];
  bit finished = 0;

  always #2 clk = ~clk;

  trace_capture #(.PROBE_W(PW), .DEPTH(DP)) uut (
    .clk(clk), .rstN(rstN), .armReq(armReq), .modeStop(modeStop),
    .trigIn(trigIn), .probeIn(probeIn), .armed(armed), .triggered(triggered),
    .wrapped(wrapped), .done(done), .rdValid(rdValid), .rdReady(rdReady),
    .rdHeader(rdHeader), .rdData(rdData)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int val(input int i, input int seed);
    return (i * 3 + seed) & 8'hFF;
  endfunction

  task automatic doArm(input bit stop);
    @(negedge clk);
    armReq = 1; modeStop = stop; trigIn = 0;
    @(negedge clk);
    armReq = 0;
    chk(armed == 1, "R2 armed after arm", armed, 1);
    chk(!done && !wrapped && !triggered, "R2 flags cleared",
        {done, wrapped, triggered}, 0);
  endtask

  task automatic drain(input int n, input bit jitter);
    int beat = 0;
    int guard = 0;
    bit prevStall = 0;
    logic [DW-1:0] prevData = '0;
    int cyc = 0;
    while (beat < n + 1 && guard < 400) begin
      if (prevStall) chk(rdValid && rdData == prevData, "R10 hold", rdData, prevData);
      if (rdValid) begin
        if (beat == 0) begin
          chk(rdHeader == 1, "R8 header flag", rdHeader, 1);
          chk(rdData == DW'(n), "R8 count", rdData, n);
        end else begin
          chk(rdHeader == 0, "R9 data flag", rdHeader, 0);
          chk(rdData == DW'(expv[beat-1]), "R9 order", rdData, expv[beat-1]);
        end
      end
      rdReady = jitter ? (cyc % 3 != 0) : 1'b1;
      if (rdValid && rdReady) beat++;
      prevStall = rdValid && !rdReady;
      prevData = rdData;
      cyc++;
      guard++;
      @(negedge clk);
    end
    rdReady = 0;
    chk(beat == n + 1, "R9 beats", beat, n + 1);
    @(negedge clk);
    chk(rdValid == 0, "R9 stream end", rdValid, 0);
  endtask

  task automatic stopRun(input int n, input int seed, input bit jitter);
    int cnt;
    doArm(1);
    for (int i = 0; i < n; i++) begin
      probeIn = PW'(val(i, seed));
      trigIn = (i == n - 1);
      @(negedge clk);
    end
    trigIn = 0;
    probeIn = 8'h55;
    chk(done == 1, "R6 done", done, 1);
    chk(triggered == 1, "R6 triggered", triggered, 1);
    chk(wrapped == (n >= DP), "R7 wrapped", wrapped, n >= DP);
    cnt = (n < DP) ? n : DP;
    for (int k = 0; k < cnt; k++) expv[k] = val(n - cnt + k, seed);
    drain(cnt, jitter);
  endtask

  task automatic startRun(input int d, input int seed, input bit jitter);
    doArm(0);
    for (int i = 0; i < d; i++) begin
      probeIn = PW'(8'hA0 + i);
      @(negedge clk);
    end
    chk(triggered == 0 && done == 0, "R4 waiting", {triggered, done}, 0);
    for (int k = 0; k < DP + 4; k++) begin
      probeIn = PW'(val(k, seed));
      trigIn = (k == 0) || (k == 3);
      @(negedge clk);
    end
    trigIn = 0;
    chk(done == 1, "R5 done", done, 1);
    chk(wrapped == 0, "R5 no wrap", wrapped, 0);
    for (int k = 0; k < DP; k++) expv[k] = val(k, seed);
    drain(DP, jitter);
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!armed && !triggered && !wrapped && !done && !rdValid, "R1 reset",
        {armed, triggered, wrapped, done, rdValid}, 0);
    rstN = 1;
    @(negedge clk);
    chk(!armed && !triggered && !wrapped && !done && !rdValid, "R1 after release",
        {armed, triggered, wrapped, done, rdValid}, 0);

    // R3: trigger before arming
    trigIn = 1;
    repeat (3) @(negedge clk);
    trigIn = 0;
    @(negedge clk);
    chk(!triggered && !done && !rdValid, "R3 idle trigger", {triggered, done, rdValid}, 0);

    // R6, R7: sweep trigger distance
    for (int n = 1; n <= 2 * DP + 2; n++) stopRun(n, n * 7, n[0]);

    // R3: trigger after readout finished
    trigIn = 1;
    repeat (2) @(negedge clk);
    trigIn = 0;
    @(negedge clk);
    chk(!rdValid && done && triggered && !armed, "R3 post trigger",
        {rdValid, done, triggered, armed}, 6);

    // R4, R5: start mode with several waits
    for (int d = 0; d < 4; d++) startRun(d, 40 + d, d[0]);

    // R2: re-arm mid-capture
    doArm(1);
    for (int i = 0; i < 5; i++) begin
      probeIn = PW'(8'hE0 + i);
      @(negedge clk);
    end
    doArm(1);
    for (int i = 0; i < 3; i++) begin
      probeIn = PW'(val(i, 99));
      trigIn = (i == 2);
      @(negedge clk);
    end
    trigIn = 0;
    for (int k = 0; k < 3; k++) expv[k] = val(k, 99);
    drain(3, 0);

    // R2: arm wins over a simultaneous trigger; wrap cleared by re-arm
    stopRun(DP + 3, 5, 1);
    @(negedge clk);
    armReq = 1; modeStop = 0; trigIn = 1;
    @(negedge clk);
    armReq = 0; trigIn = 0;
    chk(!wrapped && !triggered && armed, "R2 arm priority", {wrapped, triggered, armed}, 1);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule